// File: doc/BRIEF.md
# MII Transmit Client Feeder with Alignment-Marker Scheduling

This block sits between an upstream producer of 256-bit MII words and a transmit PCS that takes one word per clock. Each word has 32 byte lanes and a per-lane control flag. The PCS raises a ready pin. The block forms the valid strobe towards the PCS by delaying that pin through a fixed shift line of `VALID_DLY` stages. It schedules alignment-marker requests by counting only the cycles in which valid is high. A marker request stays high for 5 such cycles, and each run of low marker request lasts a full gap: 81915 valid cycles in normal operation, or 315 when the `SIM_MODE` parameter is set.

The word presented to the PCS sits in an output register. A cycle is *frozen* when valid is low or the marker request is high. The register is not allowed to change at the end of a frozen cycle, nor at the end of the cycle that follows one. A cycle in which neither applies is an *advance* cycle. At the end of an advance cycle the PCS consumes the current word, and the register loads the next one.

Upstream flow control is a valid/ready handshake. `up_ready` is high exactly in advance cycles and does not depend on `up_valid`. A word moves when `up_valid` and `up_ready` are both high at a clock edge. While `up_valid` is high and `up_ready` is low, the producer must keep the word and its flags unchanged. If an advance cycle finds no upstream word, the block loads an idle word instead, so the PCS stream never runs dry.

Top module: `mii_tx_client_drv`

## Requirements
- R1: Upstream words reach `tx_data`/`tx_ctrl` unchanged, lane for lane. Byte lane k is `tx_data[8k+7:8k]` and is qualified by `tx_ctrl[k]`, where 1 marks a control byte. Lane 0 (bits 7:0) goes first on the link, and bit 0 is the first bit sent. For example, a start code 0xFB in lane 0 travels with `tx_ctrl[0]`=1.
- R2: `tx_valid` equals the value `pcs_ready` had exactly `VALID_DLY` cycles earlier. `VALID_DLY` is between 1 and 10.
- R3: Every assertion of `tx_am` lasts exactly 5 cycles in which `tx_valid` is 1. Cycles with `tx_valid` at 0 do not count.
- R4: Between a fall of `tx_am` and its next rise, exactly GAP cycles pass with `tx_valid` at 1. GAP is 81915, or 315 when `SIM_MODE`=1. After reset the first rise also comes after exactly GAP such cycles.
- R5: In any cycle that follows a frozen cycle (`tx_valid`=0 or `tx_am`=1), `tx_data` and `tx_ctrl` equal their values from that frozen cycle. Here "frozen" refers to the earlier cycle.
- R6: `up_ready` is 1 exactly when `tx_valid`=1, `tx_am`=0 and the previous cycle was not frozen. Each accepted word is presented to the PCS in exactly one advance cycle, in order, with none lost or repeated.
- R7: When an advance cycle has `up_valid`=0, the next word is idle: 0x07 on all 32 lanes, with all `tx_ctrl` bits at 1.
- R8: While reset is held, `tx_valid`, `tx_am` and `up_ready` are 0 and the output word is the idle word of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream word present |
| up_ready | output | 1 | Block takes the upstream word at this edge |
| up_data | input | 256 | Upstream data, lane 0 first |
| up_ctrl | input | 32 | Upstream per-lane control flags |
| pcs_ready | input | 1 | PCS ready indication |
| tx_valid | output | 1 | Valid strobe to the PCS (`pcs_ready` delayed by `VALID_DLY`) |
| tx_am | output | 1 | Alignment-marker request |
| tx_data | output | 256 | Word to the PCS |
| tx_ctrl | output | 32 | Per-lane control flags to the PCS |

## Verification
`tx_valid` is due `VALID_DLY` cycles after a `pcs_ready` change. The bench measures this by counting falling edges from the drive cycle, and it also compares every cycle against a `VALID_DLY`-deep history of `pcs_ready`. A word accepted at an edge appears on `tx_data` in the next cycle, and the bench matches it at the first advance cycle after that. `tx_am` rises in the cycle after the GAP-th valid cycle, and the bench counts valid cycles at each falling edge to compare gap and marker lengths. All outputs are sampled at the falling clock edge, and inputs are driven just after the rising edge, so every registered result is settled when it is read.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int unsigned LANE_W = 8;
  localparam logic [LANE_W-1:0] IDLE_CODE = 8'h07;
endpackage

// File: rtl/mtx_valid_delay.sv
// Delays the PCS ready indication by DLY cycles to form the valid strobe.
module mtx_valid_delay #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_in,
  output logic vld_out
);
  generate
    if (DLY == 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk) begin
        if (rst) stage_q <= 1'b0;
        else     stage_q <= rdy_in;
      end
      assign vld_out = stage_q;
    end else begin : g_line
      logic [DLY-1:0] line_q;
      always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= {line_q[DLY-2:0], rdy_in};
      end
      assign vld_out = line_q[DLY-1];
    end
  endgenerate
endmodule

// File: rtl/mtx_marker_sched.sv
// Alternates a gap of GAP valid cycles with a marker request of LEN valid cycles.
module mtx_marker_sched #(
  parameter int GAP = 81915,
  parameter int LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  output logic am
);
  localparam int MAXV = (GAP > LEN) ? GAP : LEN;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP - 1);
  localparam logic [CW-1:0] LEN_LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          am_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      am_q  <= 1'b0;
    end else if (vld) begin
      if (!am_q) begin
        if (cnt_q == GAP_LAST) begin
          cnt_q <= '0;
          am_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == LEN_LAST) begin
          cnt_q <= '0;
          am_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign am = am_q;
endmodule

// File: rtl/mtx_word_stage.sv
// Output word register, one byte and one flag per lane; idle on reset or underflow.
module mtx_word_stage
  import mtx_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic                    in_valid,
  input  logic [LANES*LANE_W-1:0] in_data,
  input  logic [LANES-1:0]        in_ctrl,
  output logic [LANES*LANE_W-1:0] out_data,
  output logic [LANES-1:0]        out_ctrl
);
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [LANE_W-1:0] byte_q;
      logic              flag_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          byte_q <= IDLE_CODE;
          flag_q <= 1'b1;
        end else if (adv) begin
          if (in_valid) begin
            byte_q <= in_data[k*LANE_W +: LANE_W];
            flag_q <= in_ctrl[k];
          end else begin
            byte_q <= IDLE_CODE;
            flag_q <= 1'b1;
          end
        end
      end
      assign out_data[k*LANE_W +: LANE_W] = byte_q;
      assign out_ctrl[k]                  = flag_q;
    end
  endgenerate
endmodule

// File: rtl/mii_tx_client_drv.sv
module mii_tx_client_drv
  import mtx_pkg::*;
#(
  parameter int DATA_W      = 256,
  parameter int VALID_DLY   = 4,
  parameter int AM_LEN      = 5,
  parameter int AM_GAP_FULL = 81915,
  parameter int AM_GAP_SIM  = 315,
  parameter bit SIM_MODE    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 up_valid,
  output logic                 up_ready,
  input  logic [DATA_W-1:0]    up_data,
  input  logic [DATA_W/8-1:0]  up_ctrl,
  input  logic                 pcs_ready,
  output logic                 tx_valid,
  output logic                 tx_am,
  output logic [DATA_W-1:0]    tx_data,
  output logic [DATA_W/8-1:0]  tx_ctrl
);
  localparam int LANES  = DATA_W / LANE_W;
  localparam int AM_GAP = SIM_MODE ? AM_GAP_SIM : AM_GAP_FULL;

  logic frozen;
  logic frz_q;
  logic adv;

  mtx_valid_delay #(.DLY(VALID_DLY)) u_vdly (
    .clk    (clk),
    .rst    (rst),
    .rdy_in (pcs_ready),
    .vld_out(tx_valid)
  );

  mtx_marker_sched #(.GAP(AM_GAP), .LEN(AM_LEN)) u_msch (
    .clk(clk),
    .rst(rst),
    .vld(tx_valid),
    .am (tx_am)
  );

  assign frozen = ~tx_valid | tx_am;

  always_ff @(posedge clk) begin
    if (rst) frz_q <= 1'b1;
    else     frz_q <= frozen;
  end

  assign adv      = tx_valid & ~tx_am & ~frz_q;
  assign up_ready = adv;

  mtx_word_stage #(.LANES(LANES)) u_word (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .in_valid(up_valid),
    .in_data (up_data),
    .in_ctrl (up_ctrl),
    .out_data(tx_data),
    .out_ctrl(tx_ctrl)
  );
endmodule

// File: rtl/mtx_checker.sv
module mtx_checker #(
  parameter int DATA_W      = 256,
  parameter int VALID_DLY   = 4,
  parameter int AM_LEN      = 5,
  parameter int AM_GAP_FULL = 81915,
  parameter int AM_GAP_SIM  = 315,
  parameter bit SIM_MODE    = 1'b0
) (
  input logic                clk,
  input logic                rst,
  input logic                up_ready,
  input logic                pcs_ready,
  input logic                tx_valid,
  input logic                tx_am,
  input logic [DATA_W-1:0]   tx_data,
  input logic [DATA_W/8-1:0] tx_ctrl
);
  localparam int AM_GAP = SIM_MODE ? AM_GAP_SIM : AM_GAP_FULL;

  logic [4:0]  up_cnt;
  logic [31:0] gap_cnt;
  logic [31:0] mk_cnt;
  logic        rst_q;
  logic        frozen;

  assign frozen = ~tx_valid | tx_am;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      up_cnt  <= '0;
      gap_cnt <= '0;
      mk_cnt  <= '0;
    end else begin
      if (up_cnt != 5'd31) up_cnt <= up_cnt + 1'b1;
      if (tx_am) gap_cnt <= '0;
      else if (tx_valid) gap_cnt <= gap_cnt + 1'b1;
      if (!tx_am) mk_cnt <= '0;
      else if (tx_valid) mk_cnt <= mk_cnt + 1'b1;
    end
  end

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    (32'(up_cnt) > VALID_DLY) |-> (tx_valid == $past(pcs_ready, VALID_DLY)));

  p_mark_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_am) |-> (mk_cnt == 32'(AM_LEN)));

  p_gap_len_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_am) |-> (gap_cnt == 32'(AM_GAP)));

  p_freeze_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (up_cnt >= 5'd1 && $past(frozen)) |-> ($stable(tx_data) && $stable(tx_ctrl)));

  p_no_take_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    frozen |-> !up_ready);

  always @(posedge clk) begin
    if (rst && rst_q === 1'b1) begin
      p_reset_idle_r8: assert (!tx_valid && !tx_am && !up_ready && (&tx_ctrl)
                               && tx_data == {(DATA_W/8){8'h07}});
    end
  end
endmodule

bind mii_tx_client_drv mtx_checker #(
  .DATA_W     (DATA_W),
  .VALID_DLY  (VALID_DLY),
  .AM_LEN     (AM_LEN),
  .AM_GAP_FULL(AM_GAP_FULL),
  .AM_GAP_SIM (AM_GAP_SIM),
  .SIM_MODE   (SIM_MODE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .up_ready (up_ready),
  .pcs_ready(pcs_ready),
  .tx_valid (tx_valid),
  .tx_am    (tx_am),
  .tx_data  (tx_data),
  .tx_ctrl  (tx_ctrl)
);

// File: tb/sim_mii_tx_client_drv.sv
module sim_mii_tx_client_drv;
  localparam int DW  = 256;
  localparam int LN  = 32;
  localparam int N   = 4;
  localparam int MK  = 5;
  localparam int GAP = 315;
  localparam logic [DW+LN-1:0] IDLE_W = {{LN{1'b1}}, {LN{8'h07}}};

  // stimulus {gap before word, data seed, ctrl}; expected result: the same word on the PCS side
  localparam logic [55:0] VEC [0:11] = '{
    {8'd0, 16'h01FB, 32'h0000_0001},
    {8'd0, 16'h0310, 32'h0000_0000},
    {8'd2, 16'h0522, 32'h8000_0000},
    {8'd0, 16'h0733, 32'h0000_0000},
    {8'd5, 16'h0944, 32'hFFFF_0000},
    {8'd0, 16'h0B55, 32'h0000_FFFF},
    {8'd1, 16'h0D66, 32'h5555_5555},
    {8'd0, 16'h0F77, 32'hAAAA_AAAA},
    {8'd3, 16'h1188, 32'h0000_0000},
    {8'd0, 16'h1399, 32'h7FFF_FFFF},
    {8'd0, 16'h15AA, 32'h0000_0010},
    {8'd7, 16'h17BB, 32'h1234_5678}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_valid = 1'b0;
  logic up_ready;
  logic [DW-1:0] up_data = '0;
  logic [LN-1:0] up_ctrl = '0;
  logic pcs_ready = 1'b0;
  logic tx_valid, tx_am;
  logic [DW-1:0] tx_data;
  logic [LN-1:0] tx_ctrl;

  always #10 clk = ~clk;

  mii_tx_client_drv #(.VALID_DLY(N), .SIM_MODE(1'b1)) u0 (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
    .up_data(up_data), .up_ctrl(up_ctrl), .pcs_ready(pcs_ready),
    .tx_valid(tx_valid), .tx_am(tx_am), .tx_data(tx_data), .tx_ctrl(tx_ctrl)
  );

  int n_chk = 0;
  int n_err = 0;
  int mode = 0;
  int cyc_p = 0;
  int wr_i = 0;
  int rd_i = 0;
  int rises = 0;
  int cnt;
  int base;
  logic [DW+LN-1:0] exp_q [0:1023];

  task automatic check(input bit ok, input string tag, input logic [DW+LN-1:0] act,
                       input logic [DW+LN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk_data(input logic [15:0] seed);
    logic [DW-1:0] d;
    for (int k = 0; k < LN; k++) d[8*k +: 8] = seed[7:0] + 8'(k) * seed[15:8];
    return d;
  endfunction

  // ready pattern: three low cycles in every 23
  initial forever begin
    @(posedge clk);
    #2;
    if (mode == 2) pcs_ready = (cyc_p % 23) >= 3;
    cyc_p++;
  end

  // port monitor
  logic rst_q = 1'b0;
  logic prev_frz, prev_am, frz, adv;
  logic [DW+LN-1:0] prev_w, w;
  logic [N-1:0] hist;
  int gap_c, mk_c, since;

  always @(negedge clk) begin
    w = {tx_ctrl, tx_data};
    if (rst) begin
      if (rst_q) check(!tx_valid && !tx_am && !up_ready && w == IDLE_W,
                       "R8 reset state", {tx_valid, tx_am, up_ready, w[DW-1:0]}, IDLE_W);
      prev_frz = 1'b1; prev_am = 1'b0; prev_w = IDLE_W;
      gap_c = 0; mk_c = 0; since = 0; hist = '0;
    end else begin
      frz = !tx_valid || tx_am;
      adv = tx_valid && !tx_am && !prev_frz;
      if (prev_frz) check(w == prev_w, "R5 word held after frozen cycle", w, prev_w);
      check(up_ready == adv, "R6 upstream ready", up_ready, adv);
      if (since >= N) check(tx_valid == hist[N-1], "R2 valid follows ready", tx_valid, hist[N-1]);
      hist = {hist[N-2:0], pcs_ready};
      since++;
      if (tx_am && !prev_am) begin
        check(gap_c == GAP, "R4 marker gap", gap_c, GAP);
        gap_c = 0;
        rises++;
      end
      if (!tx_am && prev_am) begin
        check(mk_c == MK, "R3 marker length", mk_c, MK);
        mk_c = 0;
      end
      if (tx_valid) begin
        if (tx_am) mk_c++;
        else gap_c++;
      end
      if (adv && w != IDLE_W) begin
        if (rd_i < wr_i) check(w == exp_q[rd_i % 1024], "R1 R6 word content and order", w, exp_q[rd_i % 1024]);
        else check(1'b0, "R6 unexpected word", w, IDLE_W);
        rd_i++;
      end
      prev_frz = frz; prev_am = tx_am; prev_w = w;
    end
    rst_q = rst;
  end

  task automatic send(input logic [DW-1:0] d, input logic [LN-1:0] c);
    up_valid = 1'b1; up_data = d; up_ctrl = c;
    @(negedge clk);
    while (!up_ready) @(negedge clk);
    exp_q[wr_i % 1024] = {c, d};
    wr_i++;
    @(posedge clk);
    #1 up_valid = 1'b0;
  endtask

  task automatic drain();
    int g = 0;
    while (rd_i < wr_i && g < 500) begin @(negedge clk); g++; end
    check(rd_i == wr_i, "R6 every accepted word emitted once", rd_i, wr_i);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (6) @(posedge clk);
    #1 rst = 1'b0;
    // R2 directed: rise and fall delay
    @(posedge clk); #1 pcs_ready = 1'b1;
    cnt = 0; @(negedge clk);
    while (!tx_valid && cnt < 20) begin cnt++; @(negedge clk); end
    check(cnt == N, "R2 rise delay", cnt, N);
    repeat (10) @(posedge clk);
    #1 pcs_ready = 1'b0;
    cnt = 0; @(negedge clk);
    while (tx_valid && cnt < 20) begin cnt++; @(negedge clk); end
    check(cnt == N, "R2 fall delay", cnt, N);
    @(posedge clk); #1 mode = 2;
    // vector table walk (R1, R5, R6)
    for (int i = 0; i < 12; i++) begin
      repeat (int'(VEC[i][55:48])) @(posedge clk);
      if (VEC[i][55:48] != 0) #1;
      send(mk_data(VEC[i][47:32]), VEC[i][31:0]);
    end
    drain();
    // R7: no upstream word, advance cycles fill idle
    repeat (40) @(negedge clk);
    check({tx_ctrl, tx_data} == IDLE_W, "R7 idle fill", {tx_ctrl, tx_data}, IDLE_W);
    // long stream across several markers (R3, R4)
    @(posedge clk); #1;
    for (int r = 0; r < 900 && rises < 3; r++)
      send(mk_data(16'(r * 257 + 1) | 16'h0100), 32'(r));
    drain();
    check(rises >= 3, "R3 R4 markers observed", rises, 3);
    // R4: marker schedule restarts after reset (R8 checked by monitor)
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    base = rises;
    repeat (600) @(posedge clk);
    check(rises > base, "R4 restart after reset", rises, base + 1);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule